// File: doc/BRIEF.md
# Dual-Mode Padded-Window SAD Processing Element

This block is one processing element of a block-matching array. It takes two pixel windows, a reference and a candidate, one row at a time, and returns the sum of absolute differences between them. The datapath always covers an 11x11 window. Each row holds 11 pixel pairs, and one row is taken per clock.

A mode bit chooses how the window is read. In full mode all 121 pixel pairs count toward the sum. In padded mode the element works on an 8x8 block placed in the top-left corner of the window. The three trailing columns of every row and the three trailing rows are forced to zero in both operands. A padded window still occupies 11 row slots, so both modes use the same pipeline, latency and throughput. The caller supplies the rows, and this element keeps no search state.

The two row streams carry separate valid flags. A row is consumed only when both flags are high, so idle cycles may appear anywhere inside a window. The element counts accepted rows to find where each window begins and ends. It captures the mode on the first row of each window.

Top module: `sad_window_pe`

## Requirements
- R1: While reset is low, and in the first cycle after it, `sad_valid_o` is 0 and `sad_o` is 0. The first row accepted after reset is row 0 of a window.
- R2: With the window mode 0 (full), the result equals the sum over all 11 rows and 11 columns of |a - b|. Column c of a row occupies bits [8c+7:8c] of the row bus, and rows are numbered in the order they are accepted.
- R3: With the window mode 1 (padded), the result counts only rows 0..7 and columns 0..7. Pixels in rows 8..10 and in columns 8..10 have no effect on the result, whatever their values.
- R4: `sad_valid_o` is high for exactly one cycle, two rising edges after the edge that accepts row 10 of a window. The latency is the same in both modes.
- R5: A row is accepted only on an edge where `a_valid_i` and `b_valid_i` are both 1. A cycle with either flag low does not advance the window and does not affect the sum.
- R6: The mode is sampled from `mode_i` on row 0 of each window. Changes to `mode_i` on rows 1..10 have no effect on that window.
- R7: The largest possible result, 121 x 255 = 30855, is returned exactly, with no wrap.
- R8: Row 0 of a new window may be accepted on the edge right after row 10 of the previous one. Each result depends only on its own window.
- R9: `sad_o` holds its last result until the next `sad_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Window mode, sampled on row 0: 0 = full 11x11, 1 = 8x8 zero-padded |
| a_valid_i | input | 1 | Reference row is present |
| a_row_i | input | 88 | Reference row, 11 pixels of 8 bits, column 0 in the low bits |
| b_valid_i | input | 1 | Candidate row is present |
| b_row_i | input | 88 | Candidate row, same layout as the reference row |
| sad_o | output | 15 | Sum of absolute differences of the last completed window |
| sad_valid_o | output | 1 | One-cycle pulse marking a new result on `sad_o` |

## Verification
The bench sweeps a single 255-versus-0 difference across all 121 positions in both modes. A mask placed one row or one column wrong therefore shows up as a nonzero result where zero is expected, or the reverse. Random windows in padded mode fill the padding area with noise, so a design that pads only one operand returns a sum that is too large. A mode flipped after row 0, a single-valid gap cycle and two windows run back to back catch three faults: a mode that is not latched, a half-valid row counted as accepted, and an accumulator that is not cleared. The all-maximum window catches an accumulator that is too narrow, which would wrap below 30855.

// File: rtl/sad_pe_pkg.sv
package sad_pe_pkg;

    typedef enum logic {
        MODE_FULL = 1'b0,
        MODE_PAD  = 1'b1
    } win_mode_e;

    localparam int DEF_PIX_W = 8;
    localparam int DEF_WIN   = 11;
    localparam int DEF_BLK   = 8;

endpackage

// File: rtl/sad_row_ctrl.sv
module sad_row_ctrl
    import sad_pe_pkg::*;
#(
    parameter int WIN = DEF_WIN,
    localparam int CNT_W = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  win_mode_e        mode_i,
    output logic [CNT_W-1:0] row_idx_o,
    output win_mode_e        mode_o,
    output logic             first_o,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        win_mode_e        mode;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        first_o   = (ctl_q.cnt == '0);
        last_o    = (ctl_q.cnt == CNT_W'(WIN - 1));
        row_idx_o = ctl_q.cnt;
        mode_o    = first_o ? mode_i : ctl_q.mode;
        if (accept_i) begin
            if (first_o) begin
                ctl_d.mode = mode_i;
            end
            ctl_d.cnt = last_o ? '0 : ctl_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cnt: '0, mode: MODE_FULL};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/sad_absdiff_row.sv
module sad_absdiff_row
    import sad_pe_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    localparam int ROW_BITS = PIX_W * WIN
) (
    input  logic [ROW_BITS-1:0]       a_row_i,
    input  logic [ROW_BITS-1:0]       b_row_i,
    input  logic [WIN-1:0]            lane_en_i,
    output logic [WIN-1:0][PIX_W-1:0] diff_o
);

    for (genvar g = 0; g < WIN; g++) begin : g_lane
        logic [PIX_W-1:0] av, bv, mag;
        assign av  = a_row_i[g*PIX_W +: PIX_W];
        assign bv  = b_row_i[g*PIX_W +: PIX_W];
        assign mag = (av >= bv) ? (av - bv) : (bv - av);
        // a masked lane stands for zero in both operands, so it adds nothing
        assign diff_o[g] = lane_en_i[g] ? mag : '0;
    end

endmodule

// File: rtl/sad_lane_sum.sv
module sad_lane_sum
    import sad_pe_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    localparam int SUM_W = $clog2(WIN * ((1 << PIX_W) - 1) + 1)
) (
    input  logic [WIN-1:0][PIX_W-1:0] diff_i,
    output logic [SUM_W-1:0]          sum_o
);

    always_comb begin
        sum_o = '0;
        for (int i = 0; i < WIN; i++) begin
            sum_o = sum_o + SUM_W'(diff_i[i]);
        end
    end

endmodule

// File: rtl/sad_window_pe.sv
module sad_window_pe
    import sad_pe_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    parameter int BLK   = DEF_BLK,
    localparam int ROW_BITS = PIX_W * WIN,
    localparam int CNT_W    = $clog2(WIN),
    localparam int ROW_W    = $clog2(WIN * ((1 << PIX_W) - 1) + 1),
    localparam int ACC_W    = $clog2(WIN * WIN * ((1 << PIX_W) - 1) + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_i,
    input  logic                a_valid_i,
    input  logic [ROW_BITS-1:0] a_row_i,
    input  logic                b_valid_i,
    input  logic [ROW_BITS-1:0] b_row_i,
    output logic [ACC_W-1:0]    sad_o,
    output logic                sad_valid_o
);

    typedef struct packed {
        logic [WIN-1:0][PIX_W-1:0] s1_diff;
        logic                      s1_valid;
        logic                      s1_first;
        logic                      s1_last;
        logic [ACC_W-1:0]          acc;
        logic [ACC_W-1:0]          sad;
        logic                      out_valid;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic                      accept;
    logic [CNT_W-1:0]          row_idx;
    win_mode_e                 mode_eff;
    logic                      row_first;
    logic                      row_last;
    logic [WIN-1:0]            lane_en;
    logic [WIN-1:0][PIX_W-1:0] diff_row;
    logic [ROW_W-1:0]          row_sum;
    logic [ACC_W-1:0]          acc_next;

    assign accept = a_valid_i && b_valid_i;

    sad_row_ctrl #(.WIN(WIN)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .mode_i    (win_mode_e'(mode_i)),
        .row_idx_o (row_idx),
        .mode_o    (mode_eff),
        .first_o   (row_first),
        .last_o    (row_last)
    );

    // padding: trailing columns in every row, every column in trailing rows
    always_comb begin
        for (int c = 0; c < WIN; c++) begin
            lane_en[c] = (mode_eff == MODE_FULL) ||
                         ((c < BLK) && (int'(row_idx) < BLK));
        end
    end

    sad_absdiff_row #(.PIX_W(PIX_W), .WIN(WIN)) absdiff_i (
        .a_row_i   (a_row_i),
        .b_row_i   (b_row_i),
        .lane_en_i (lane_en),
        .diff_o    (diff_row)
    );

    sad_lane_sum #(.PIX_W(PIX_W), .WIN(WIN)) lane_sum_i (
        .diff_i (pipe_q.s1_diff),
        .sum_o  (row_sum)
    );

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.s1_valid  = accept;
        pipe_d.s1_first  = accept && row_first;
        pipe_d.s1_last   = accept && row_last;
        if (accept) begin
            pipe_d.s1_diff = diff_row;
        end

        acc_next         = (pipe_q.s1_first ? '0 : pipe_q.acc) + ACC_W'(row_sum);
        pipe_d.out_valid = 1'b0;
        if (pipe_q.s1_valid) begin
            pipe_d.acc = acc_next;
            if (pipe_q.s1_last) begin
                pipe_d.sad       = acc_next;
                pipe_d.out_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign sad_o       = pipe_q.sad;
    assign sad_valid_o = pipe_q.out_valid;

endmodule

// File: rtl/sad_window_pe_chk.sv
module sad_window_pe_chk
    import sad_pe_pkg::*;
#(
    parameter int PIX_W = DEF_PIX_W,
    parameter int WIN   = DEF_WIN,
    localparam int CNT_W = $clog2(WIN),
    localparam int ACC_W = $clog2(WIN * WIN * ((1 << PIX_W) - 1) + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic             row_last,
    input logic [CNT_W-1:0] row_idx,
    input win_mode_e        mode_eff,
    input logic [ACC_W-1:0] sad_o,
    input logic             sad_valid_o
);

    localparam logic [ACC_W-1:0] MAX_SAD = ACC_W'(WIN * WIN * ((1 << PIX_W) - 1));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !sad_valid_o);

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid_o |=> !sad_valid_o);

    // R4
    pulse_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid_o |-> $past(accept && row_last, 2));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx != '0) |-> $stable(mode_eff));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid_o |-> (sad_o <= MAX_SAD));

    // R8
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx < CNT_W'(WIN));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sad_valid_o |-> $stable(sad_o));

endmodule

bind sad_window_pe sad_window_pe_chk #(.PIX_W(PIX_W), .WIN(WIN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .row_last    (row_last),
    .row_idx     (row_idx),
    .mode_eff    (mode_eff),
    .sad_o       (sad_o),
    .sad_valid_o (sad_valid_o)
);

// File: tb/sad_window_pe_tb.sv
module sad_window_pe_tb_top;

    localparam int PW = 8;
    localparam int W  = 11;
    localparam int BK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          a_valid_i = 1'b0;
    logic          b_valid_i = 1'b0;
    logic [PW*W-1:0] a_row_i = '0;
    logic [PW*W-1:0] b_row_i = '0;
    logic [14:0]   sad_o;
    logic          sad_valid_o;

    int checks = 0;
    int errors = 0;
    int pa [W][W];
    int pb [W][W];
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    sad_window_pe dut_i (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
        .a_valid_i (a_valid_i), .a_row_i (a_row_i),
        .b_valid_i (b_valid_i), .b_row_i (b_row_i),
        .sad_o (sad_o), .sad_valid_o (sad_valid_o)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int next_pix();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return int'(rng[7:0]);
    endfunction

    task automatic fill_rand();
        for (int r = 0; r < W; r++)
            for (int c = 0; c < W; c++) begin
                pa[r][c] = next_pix();
                pb[r][c] = next_pix();
            end
    endtask

    task automatic fill_const(input int va, input int vb);
        for (int r = 0; r < W; r++)
            for (int c = 0; c < W; c++) begin
                pa[r][c] = va;
                pb[r][c] = vb;
            end
    endtask

    function automatic int expect_sad(input logic m);
        int s = 0;
        for (int r = 0; r < W; r++)
            for (int c = 0; c < W; c++)
                if (!m || (r < BK && c < BK))
                    s += (pa[r][c] > pb[r][c]) ? pa[r][c] - pb[r][c] : pb[r][c] - pa[r][c];
        return s;
    endfunction

    // drives 11 accepted rows starting at a negedge, returns at the negedge after row 10
    task automatic drive_window(input logic m, input bit flip, input bit gap);
        for (int r = 0; r < W; r++) begin
            if (gap && r == 5) begin
                a_valid_i = 1'b1;
                b_valid_i = 1'b0;
                a_row_i   = '1;
                b_row_i   = '0;
                @(posedge clk); @(negedge clk);
            end
            for (int c = 0; c < W; c++) begin
                a_row_i[c*PW +: PW] = PW'(pa[r][c]);
                b_row_i[c*PW +: PW] = PW'(pb[r][c]);
            end
            mode_i    = (r == 0) ? m : (flip ? ~m : m);
            a_valid_i = 1'b1;
            b_valid_i = 1'b1;
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic check_tail(input int exp, input string tag);
        a_valid_i = 1'b0;
        b_valid_i = 1'b0;
        check_eq({tag, " R4 early valid"}, int'(sad_valid_o), 0);
        @(negedge clk);
        check_eq({tag, " R4 valid"}, int'(sad_valid_o), 1);
        check_eq({tag, " sad"}, int'(sad_o), exp);
        @(negedge clk);
        check_eq({tag, " R4 pulse width"}, int'(sad_valid_o), 0);
        check_eq({tag, " R9 hold"}, int'(sad_o), exp);
    endtask

    task automatic run_window(input logic m, input bit flip, input bit gap, input string tag);
        int e;
        e = expect_sad(m);
        drive_window(m, flip, gap);
        check_tail(e, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 valid in reset", int'(sad_valid_o), 0);
        check_eq("R1 sad in reset", int'(sad_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 valid after reset", int'(sad_valid_o), 0);

        fill_const(0, 0);     run_window(1'b0, 0, 0, "R2 zeros");
        fill_const(255, 0);   run_window(1'b0, 0, 0, "R7 max full");
        fill_const(0, 255);   run_window(1'b1, 0, 0, "R3 max padded");
        fill_const(77, 77);   run_window(1'b0, 0, 0, "R2 equal");
        for (int k = 0; k < 6; k++) begin
            fill_rand(); run_window(1'b0, 0, 0, "R2 random");
            fill_rand(); run_window(1'b1, 0, 0, "R3 random padded");
        end
        fill_rand(); run_window(1'b0, 1, 0, "R6 flip to padded");
        fill_rand(); run_window(1'b1, 1, 0, "R6 flip to full");
        fill_rand(); run_window(1'b0, 0, 1, "R5 gap full");
        fill_rand(); run_window(1'b1, 0, 1, "R5 gap padded");

        // R8: second window starts right after the first
        begin
            int e1, e2;
            fill_const(255, 0);
            e1 = expect_sad(1'b0);
            drive_window(1'b0, 0, 0);
            fill_rand();
            e2 = expect_sad(1'b1);
            fork
                drive_window(1'b1, 0, 0);
                begin
                    check_eq("R8 first early valid", int'(sad_valid_o), 0);
                    @(negedge clk);
                    check_eq("R8 first valid", int'(sad_valid_o), 1);
                    check_eq("R8 first sad", int'(sad_o), e1);
                end
            join
            check_tail(e2, "R8 second");
        end

        // R2/R3 sweep: one differing pixel at every position, both modes
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < W; r++)
                for (int c = 0; c < W; c++) begin
                    fill_const(0, 0);
                    if (m == 1) pb[r][c] = 255; else pa[r][c] = 255;
                    run_window(logic'(m), 0, 0, (m == 1) ? "R3 sweep" : "R2 sweep");
                end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule